// File: doc/BRIEF.md
# EEPROM Page-Write Engine

This block is a clock-sampled model of the control logic inside a 512 x 8 byte-alterable nonvolatile memory. It sits behind an asynchronous-style memory pin set: a 9-bit address, an 8-bit data path split into input, output and output-enable, and three active-low controls for select, read enable and write enable. All pins are sampled on the system clock. Reads return stored bytes two cycles after the pins settle. Writes are gathered into a 16-byte page buffer.

After the first byte of a write burst, further bytes to the same page may follow. Each new strobe restarts a load window. When the window runs out with no strobe in progress, an internal programming cycle starts. When that cycle ends, every loaded byte of the page is committed to the array in one step.

While programming is under way, a read of the most recently loaded address returns that byte with its top bit inverted. The host can poll this bit to find out when programming has finished. All timing values are parameters counted in clock cycles: the noise threshold, the load window and the programming time.

Top module: `eeprom_page_writer`

## Requirements
- R1: `rdata_oe` is high only when `sel_n` and `rden_n` were low and `wren_n` was high at the pins two cycles earlier. When `rdata_oe` is low, `rdata_o` is zero.
- R2: A read returns the byte most recently committed at that address. The address is split into a page number (bits 8..4) and an offset within the page (bits 3..0).
- R3: A write strobe exists only while `sel_n` and `wren_n` are low and `rden_n` is high. Pulling `wren_n` low while `rden_n` is low, or while `sel_n` is high, writes nothing.
- R4: The address is taken in the first cycle of a strobe. The data is the last value seen while the strobe was still active.
- R5: A strobe lasting fewer than GLITCH_CYC sampled cycles is discarded. A strobe lasting exactly GLITCH_CYC cycles is accepted.
- R6: Once loading has begun, programming starts only after WINDOW_CYC consecutive cycles with no strobe in progress. Any new strobe restarts that count.
- R7: A burst of 1 to 16 bytes is committed in a single step. Bytes of the page that were not loaded keep their previous contents.
- R8: For the PROG_CYC cycles of programming, a read of the last loaded address returns that byte with bit 7 inverted. Reads of other addresses return the stored data. After programming, the true data is returned.
- R9: Strobes that arrive during programming have no effect on the array, on the page buffer or on the address being polled.
- R10: A strobe to a different page during loading is discarded and sets `page_err`. `page_err` stays set until the first byte of the next burst is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Active-low device select |
| rden_n | input | 1 | Active-low read enable |
| wren_n | input | 1 | Active-low write strobe |
| addr_i | input | 9 | Byte address |
| wdata_i | input | 8 | Write data from the bus |
| rdata_o | output | 8 | Read data, zero when not driving |
| rdata_oe | output | 1 | Drive enable for the data bus |
| page_err | output | 1 | Set by a strobe to a foreign page during loading |

## Verification
A table first runs multi-byte and single-byte bursts to separate pages. Each burst is read once while programming is under way and once after commit, which separates the inverted status bit from the true data.

Directed patterns then cover several cases:
- Strobes of two and three cycles, which locate the noise threshold.
- Strobes with read enable low or select high, which must write nothing.
- A strobe whose address and data change midway, which shows where each is captured.
- A foreign-page strobe within a burst.
- Strobes during programming.
- Gaps shorter than the window, which must keep the page open.
- A full 16-byte page and a one-byte partial update, which together show that the commit is page-wide yet honours the per-byte mask.

// File: rtl/eepw_pkg.sv
package eepw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } eng_state_t;
endpackage

// File: rtl/eepw_sampler.sv
// Samples the pins, finds write strobes, filters short pulses and
// captures the address at strobe start and the data at strobe end.
module eepw_sampler #(
  parameter int ADDR_W     = 9,
  parameter int DATA_W     = 8,
  parameter int GLITCH_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              rden_n,
  input  logic              wren_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              stb_act,
  output logic              stb_begin,
  output logic              wr_accept,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              rd_ok,
  output logic [ADDR_W-1:0] rd_addr
);
  localparam int LEN_W = $clog2(GLITCH_CYC + 1);
  localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(GLITCH_CYC);

  logic              sel_q, rden_q, wren_q, stb_prev_q;
  logic [ADDR_W-1:0] addr_q, cap_addr_q, cap_addr_d;
  logic [DATA_W-1:0] wdata_q, cap_data_q, cap_data_d;
  logic [LEN_W-1:0]  len_q, len_d;
  logic              stb_now;

  always_comb begin
    // R3: strobe needs select and write low with read enable high
    stb_now    = !sel_q && !wren_q && rden_q;
    len_d      = len_q;
    cap_addr_d = cap_addr_q;
    cap_data_d = cap_data_q;
    if (stb_now && !stb_prev_q) begin
      len_d      = LEN_W'(1);
      cap_addr_d = addr_q;
    end else if (stb_now && (len_q != LEN_MAX)) begin
      len_d = len_q + 1'b1;
    end
    if (stb_now) begin
      cap_data_d = wdata_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q      <= 1'b1;
      rden_q     <= 1'b1;
      wren_q     <= 1'b1;
      addr_q     <= '0;
      wdata_q    <= '0;
      stb_prev_q <= 1'b0;
      len_q      <= '0;
      cap_addr_q <= '0;
      cap_data_q <= '0;
    end else begin
      sel_q      <= sel_n;
      rden_q     <= rden_n;
      wren_q     <= wren_n;
      addr_q     <= addr_i;
      wdata_q    <= wdata_i;
      stb_prev_q <= stb_now;
      len_q      <= len_d;
      cap_addr_q <= cap_addr_d;
      cap_data_q <= cap_data_d;
    end
  end

  assign stb_act   = stb_now;
  assign stb_begin = stb_now && !stb_prev_q;
  // R5: only strobes that lasted the full noise threshold are taken
  assign wr_accept = !stb_now && stb_prev_q && (len_q >= LEN_MAX);
  assign wr_addr   = cap_addr_q;
  assign wr_data   = cap_data_q;
  assign rd_ok     = !sel_q && !rden_q && wren_q;
  assign rd_addr   = addr_q;
endmodule

// File: rtl/eepw_seq.sv
// Load-window and programming timers.
module eepw_seq
  import eepw_pkg::*;
#(
  parameter int WINDOW_CYC = 1000,
  parameter int PROG_CYC   = 250000,
  localparam int WIN_W     = $clog2(WINDOW_CYC + 1),
  localparam int PRG_W     = $clog2(PROG_CYC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stb_act,
  input  logic             stb_begin,
  input  logic             wr_accept,
  output eng_state_t       st_o,
  output logic [WIN_W-1:0] win_o,
  output logic [PRG_W-1:0] prog_o,
  output logic             commit_o
);
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WINDOW_CYC - 1);
  localparam logic [PRG_W-1:0] PRG_LAST = PRG_W'(PROG_CYC - 1);

  eng_state_t       st_q, st_d;
  logic [WIN_W-1:0] win_q, win_d;
  logic [PRG_W-1:0] prg_q, prg_d;
  logic             commit;

  always_comb begin
    st_d   = st_q;
    win_d  = win_q;
    prg_d  = prg_q;
    commit = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (wr_accept) begin
          st_d  = ST_LOAD;
          win_d = '0;
        end
      end
      ST_LOAD: begin
        // R6: any strobe start reopens the window
        if (stb_begin) begin
          win_d = '0;
        end else if (!stb_act) begin
          if (win_q == WIN_LAST) begin
            st_d  = ST_PROG;
            prg_d = '0;
          end else begin
            win_d = win_q + 1'b1;
          end
        end
      end
      ST_PROG: begin
        // R8: fixed programming time, then commit
        if (prg_q == PRG_LAST) begin
          st_d   = ST_IDLE;
          commit = 1'b1;
        end else begin
          prg_d = prg_q + 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      win_q <= '0;
      prg_q <= '0;
    end else begin
      st_q  <= st_d;
      win_q <= win_d;
      prg_q <= prg_d;
    end
  end

  assign st_o     = st_q;
  assign win_o    = win_q;
  assign prog_o   = prg_q;
  assign commit_o = commit;
endmodule

// File: rtl/eepw_pagebuf.sv
// Page buffer: byte lanes, load mask, page tag, last-byte record, error flag.
module eepw_pagebuf
  import eepw_pkg::*;
#(
  parameter int ADDR_W     = 9,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 16,
  localparam int OFS_W     = $clog2(PAGE_BYTES),
  localparam int TAG_W     = ADDR_W - OFS_W
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  eng_state_t                          st,
  input  logic                                wr_accept,
  input  logic [ADDR_W-1:0]                   wr_addr,
  input  logic [DATA_W-1:0]                   wr_data,
  output logic [PAGE_BYTES-1:0]               mask_o,
  output logic [TAG_W-1:0]                    tag_o,
  output logic [PAGE_BYTES-1:0][DATA_W-1:0]   lanes_o,
  output logic [ADDR_W-1:0]                   last_addr_o,
  output logic [DATA_W-1:0]                   last_data_o,
  output logic                                page_err_o
);
  logic [PAGE_BYTES-1:0]             mask_q, mask_d;
  logic [TAG_W-1:0]                  tag_q, tag_d;
  logic [PAGE_BYTES-1:0][DATA_W-1:0] lane_q;
  logic [ADDR_W-1:0]                 last_addr_q, last_addr_d;
  logic [DATA_W-1:0]                 last_data_q, last_data_d;
  logic                              err_q, err_d;
  logic                              take_first, take_more, reject, take;
  logic [OFS_W-1:0]                  ofs;
  logic                              same_page;

  always_comb begin
    ofs        = wr_addr[OFS_W-1:0];
    same_page  = (wr_addr[ADDR_W-1:OFS_W] == tag_q);
    // R9: nothing is taken in ST_PROG
    take_first = wr_accept && (st == ST_IDLE);
    take_more  = wr_accept && (st == ST_LOAD) && same_page;
    // R10: a foreign page during loading is dropped
    reject     = wr_accept && (st == ST_LOAD) && !same_page;
    take       = take_first || take_more;

    mask_d      = mask_q;
    tag_d       = tag_q;
    last_addr_d = last_addr_q;
    last_data_d = last_data_q;
    err_d       = err_q;
    if (take_first) begin
      mask_d = PAGE_BYTES'(1) << ofs;
      tag_d  = wr_addr[ADDR_W-1:OFS_W];
      err_d  = 1'b0;
    end else if (take_more) begin
      mask_d = mask_q | (PAGE_BYTES'(1) << ofs);
    end
    if (reject) begin
      err_d = 1'b1;
    end
    if (take) begin
      last_addr_d = wr_addr;
      last_data_d = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q      <= '0;
      tag_q       <= '0;
      last_addr_q <= '0;
      last_data_q <= '0;
      err_q       <= 1'b0;
    end else begin
      mask_q      <= mask_d;
      tag_q       <= tag_d;
      last_addr_q <= last_addr_d;
      last_data_q <= last_data_d;
      err_q       <= err_d;
    end
  end

  // datapath lanes carry no reset; the mask qualifies them
  always_ff @(posedge clk) begin
    for (int i = 0; i < PAGE_BYTES; i++) begin
      if (take && (ofs == OFS_W'(i))) begin
        lane_q[i] <= wr_data;
      end
    end
  end

  assign mask_o      = mask_q;
  assign tag_o       = tag_q;
  assign lanes_o     = lane_q;
  assign last_addr_o = last_addr_q;
  assign last_data_o = last_data_q;
  assign page_err_o  = err_q;
endmodule

// File: rtl/eepw_array.sv
// Storage split into one bank per byte lane so that a whole page commits at once.
module eepw_array #(
  parameter int ADDR_W     = 9,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 16,
  localparam int OFS_W     = $clog2(PAGE_BYTES),
  localparam int TAG_W     = ADDR_W - OFS_W,
  localparam int PAGES     = 1 << TAG_W
) (
  input  logic                              clk,
  input  logic                              commit,
  input  logic [PAGE_BYTES-1:0]             mask,
  input  logic [TAG_W-1:0]                  tag,
  input  logic [PAGE_BYTES-1:0][DATA_W-1:0] lanes,
  input  logic [ADDR_W-1:0]                 rd_addr,
  output logic [DATA_W-1:0]                 rd_data
);
  logic [DATA_W-1:0] lane_rd [PAGE_BYTES];

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_lane
    logic [DATA_W-1:0] bank [PAGES];
    // R7: only loaded lanes are written on commit
    always_ff @(posedge clk) begin
      if (commit && mask[g]) begin
        bank[tag] <= lanes[g];
      end
    end
    assign lane_rd[g] = bank[rd_addr[ADDR_W-1:OFS_W]];
  end

  assign rd_data = lane_rd[rd_addr[OFS_W-1:0]];
endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer
  import eepw_pkg::*;
#(
  parameter int ADDR_W     = 9,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 16,
  parameter int GLITCH_CYC = 2,
  parameter int WINDOW_CYC = 1000,
  parameter int PROG_CYC   = 250000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              rden_n,
  input  logic              wren_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rdata_oe,
  output logic              page_err
);
  localparam int OFS_W = $clog2(PAGE_BYTES);
  localparam int TAG_W = ADDR_W - OFS_W;
  localparam int WIN_W = $clog2(WINDOW_CYC + 1);
  localparam int PRG_W = $clog2(PROG_CYC + 1);

  logic rst_s0, rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s0    <= 1'b0;
      rst_int_n <= 1'b0;
    end else begin
      rst_s0    <= 1'b1;
      rst_int_n <= rst_s0;
    end
  end

  logic                              stb_act, stb_begin, wr_accept, rd_ok;
  logic [ADDR_W-1:0]                 wr_addr, rd_addr, last_addr;
  logic [DATA_W-1:0]                 wr_data, last_data, arr_rd;
  eng_state_t                        st;
  logic [WIN_W-1:0]                  win_cnt;
  logic [PRG_W-1:0]                  prog_cnt;
  logic                              commit;
  logic [PAGE_BYTES-1:0]             mask;
  logic [TAG_W-1:0]                  tag;
  logic [PAGE_BYTES-1:0][DATA_W-1:0] lanes;

  eepw_sampler #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .GLITCH_CYC(GLITCH_CYC)
  ) u_sampler (
    .clk(clk), .rst_n(rst_int_n),
    .sel_n(sel_n), .rden_n(rden_n), .wren_n(wren_n),
    .addr_i(addr_i), .wdata_i(wdata_i),
    .stb_act(stb_act), .stb_begin(stb_begin), .wr_accept(wr_accept),
    .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_ok(rd_ok), .rd_addr(rd_addr)
  );

  eepw_seq #(
    .WINDOW_CYC(WINDOW_CYC), .PROG_CYC(PROG_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_int_n),
    .stb_act(stb_act), .stb_begin(stb_begin), .wr_accept(wr_accept),
    .st_o(st), .win_o(win_cnt), .prog_o(prog_cnt), .commit_o(commit)
  );

  eepw_pagebuf #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BYTES(PAGE_BYTES)
  ) u_pagebuf (
    .clk(clk), .rst_n(rst_int_n), .st(st),
    .wr_accept(wr_accept), .wr_addr(wr_addr), .wr_data(wr_data),
    .mask_o(mask), .tag_o(tag), .lanes_o(lanes),
    .last_addr_o(last_addr), .last_data_o(last_data),
    .page_err_o(page_err)
  );

  eepw_array #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BYTES(PAGE_BYTES)
  ) u_array (
    .clk(clk), .commit(commit), .mask(mask), .tag(tag), .lanes(lanes),
    .rd_addr(rd_addr), .rd_data(arr_rd)
  );

  logic [DATA_W-1:0] rd_val, dout_d;
  logic              oe_d;

  always_comb begin
    // R8: polled address shows inverted top bit while programming
    if ((st == ST_PROG) && (rd_addr == last_addr)) begin
      rd_val = {~last_data[DATA_W-1], last_data[DATA_W-2:0]};
    end else begin
      rd_val = arr_rd;
    end
    oe_d   = rd_ok;
    dout_d = rd_ok ? rd_val : '0;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      rdata_o  <= '0;
      rdata_oe <= 1'b0;
    end else begin
      rdata_o  <= dout_d;
      rdata_oe <= oe_d;
    end
  end
endmodule

// File: rtl/eepw_chk.sv
module eepw_chk
  import eepw_pkg::*;
#(
  parameter int WINDOW_CYC = 1000,
  parameter int PROG_CYC   = 250000,
  parameter int PAGE_BYTES = 16,
  localparam int WIN_W     = $clog2(WINDOW_CYC + 1),
  localparam int PRG_W     = $clog2(PROG_CYC + 1)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  sel_n,
  input logic                  rden_n,
  input logic                  wren_n,
  input logic                  rdata_oe,
  input logic                  page_err,
  input eng_state_t            st,
  input logic [WIN_W-1:0]      win_cnt,
  input logic [PRG_W-1:0]      prog_cnt,
  input logic [PAGE_BYTES-1:0] mask
);
  // R1
  rd_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_oe |-> $past(!sel_n && !rden_n && wren_n, 2));

  // R6
  prog_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_PROG && $past(st) != ST_PROG) |->
      ($past(st) == ST_LOAD && $past(win_cnt) == WIN_W'(WINDOW_CYC - 1)));

  // R8
  prog_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == ST_PROG && st != ST_PROG) |->
      ($past(prog_cnt) == PRG_W'(PROG_CYC - 1)));

  // R9
  prog_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_PROG && $past(st) == ST_PROG) |-> $stable(mask));

  // R7
  prog_has_bytes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_PROG) |-> (mask != '0));

  // R10
  err_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(page_err) |-> ($past(st) == ST_LOAD));
endmodule

bind eeprom_page_writer eepw_chk #(
  .WINDOW_CYC(WINDOW_CYC), .PROG_CYC(PROG_CYC), .PAGE_BYTES(PAGE_BYTES)
) u_eepw_chk (
  .clk(clk), .rst_n(rst_int_n),
  .sel_n(sel_n), .rden_n(rden_n), .wren_n(wren_n),
  .rdata_oe(rdata_oe), .page_err(page_err),
  .st(st), .win_cnt(win_cnt), .prog_cnt(prog_cnt), .mask(mask)
);

// File: tb/test_eeprom_page_writer.sv
module test_eeprom_page_writer;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       sel_n, rden_n, wren_n;
  logic [8:0] addr_i;
  logic [7:0] wdata_i, rdata_o;
  logic       rdata_oe, page_err;
  int         total = 0;
  int         bad   = 0;

  always #10 clk = ~clk;

  eeprom_page_writer #(
    .GLITCH_CYC(3), .WINDOW_CYC(40), .PROG_CYC(300)
  ) i_eeprom_page_writer (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .rden_n(rden_n), .wren_n(wren_n),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .rdata_oe(rdata_oe), .page_err(page_err)
  );

  // {op, addr, data, expect}: op 0 write, 1 read, 2 wait data cycles
  localparam int NV = 17;
  localparam logic [26:0] VEC [NV] = '{
    {2'd0, 9'h020, 8'hA5, 8'h00}, {2'd0, 9'h021, 8'h3C, 8'h00},
    {2'd0, 9'h02F, 8'h7E, 8'h00}, {2'd2, 9'h000, 8'd60, 8'h00},
    {2'd1, 9'h02F, 8'h00, 8'hFE}, {2'd2, 9'h000, 8'd255, 8'h00},
    {2'd2, 9'h000, 8'd150, 8'h00}, {2'd1, 9'h02F, 8'h00, 8'h7E},
    {2'd1, 9'h020, 8'h00, 8'hA5}, {2'd1, 9'h021, 8'h00, 8'h3C},
    {2'd0, 9'h1F5, 8'h81, 8'h00}, {2'd2, 9'h000, 8'd60, 8'h00},
    {2'd1, 9'h1F5, 8'h00, 8'h01}, {2'd2, 9'h000, 8'd255, 8'h00},
    {2'd2, 9'h000, 8'd150, 8'h00}, {2'd1, 9'h1F5, 8'h00, 8'h81},
    {2'd1, 9'h020, 8'h00, 8'hA5}
  };

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [8:0] a, input logic [7:0] d, input int len);
    addr_i = a; wdata_i = d; rden_n = 1'b1; sel_n = 1'b0; wren_n = 1'b0;
    repeat (len) @(negedge clk);
    wren_n = 1'b1; sel_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic rd(input logic [8:0] a, input logic sel, output logic [7:0] d,
                    output logic oe);
    addr_i = a; sel_n = sel; rden_n = 1'b0; wren_n = 1'b1;
    repeat (2) @(negedge clk);
    d = rdata_o; oe = rdata_oe;
    sel_n = 1'b1; rden_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic rd_chk(input string tag, input logic [8:0] a, input logic [7:0] exp);
    logic [7:0] d;
    logic       oe;
    rd(a, 1'b0, d, oe);
    chk(tag, d, exp);
  endtask

  localparam int SETTLE = 450;

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog got=timeout exp=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic       oe;
    rst_n = 1'b0; sel_n = 1'b1; rden_n = 1'b1; wren_n = 1'b1;
    addr_i = '0; wdata_i = '0;
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // reset state (R1, R10)
    chk("R1 reset oe", {7'd0, rdata_oe}, 8'h00);
    chk("R1 reset data", rdata_o, 8'h00);
    chk("R10 reset err", {7'd0, page_err}, 8'h00);

    // table walk: R2 R7 R8
    for (int k = 0; k < NV; k++) begin
      logic [26:0] v;
      v = VEC[k];
      case (v[26:25])
        2'd0: wr(v[24:16], v[15:8], 4);
        2'd1: rd_chk("R2/R8 table", v[24:16], v[7:0]);
        default: idle(int'(v[15:8]));
      endcase
    end

    // R1: select high with read enable low does not drive
    rd(9'h020, 1'b1, d, oe);
    chk("R1 deselected oe", {7'd0, oe}, 8'h00);
    chk("R1 deselected data", d, 8'h00);
    rd(9'h020, 1'b0, d, oe);
    chk("R1 selected oe", {7'd0, oe}, 8'h01);

    // R5: noise threshold of 3 cycles
    wr(9'h030, 8'h22, 4); idle(SETTLE);
    wr(9'h030, 8'h11, 2); idle(60);
    rd_chk("R5 short pulse no prog", 9'h030, 8'h22);
    idle(SETTLE);
    rd_chk("R5 short pulse no write", 9'h030, 8'h22);
    wr(9'h031, 8'h44, 3); idle(SETTLE);
    rd_chk("R5 exact threshold", 9'h031, 8'h44);

    // R3: inhibited strobes
    addr_i = 9'h030; wdata_i = 8'h00; sel_n = 1'b0; wren_n = 1'b0; rden_n = 1'b0;
    idle(5);
    sel_n = 1'b1; wren_n = 1'b1; rden_n = 1'b1;
    addr_i = 9'h031; sel_n = 1'b1; wren_n = 1'b0;
    idle(5);
    wren_n = 1'b1;
    idle(SETTLE);
    rd_chk("R3 read enable low inhibits", 9'h030, 8'h22);
    rd_chk("R3 select high inhibits", 9'h031, 8'h44);

    // R4: address at start, data at end
    addr_i = 9'h0A0; wdata_i = 8'h00; rden_n = 1'b1; sel_n = 1'b0; wren_n = 1'b0;
    idle(2);
    addr_i = 9'h0A5; wdata_i = 8'h5A;
    idle(2);
    sel_n = 1'b1; wren_n = 1'b1;
    idle(SETTLE);
    rd_chk("R4 capture points", 9'h0A0, 8'h5A);

    // R10: foreign page in a burst
    wr(9'h050, 8'h55, 4); idle(SETTLE);
    wr(9'h040, 8'h10, 4);
    wr(9'h050, 8'h20, 4);
    idle(2);
    chk("R10 err set", {7'd0, page_err}, 8'h01);
    idle(SETTLE);
    rd_chk("R10 first page kept", 9'h040, 8'h10);
    rd_chk("R10 foreign byte dropped", 9'h050, 8'h55);
    chk("R10 err sticky", {7'd0, page_err}, 8'h01);
    wr(9'h041, 8'h33, 4);
    idle(2);
    chk("R10 err cleared", {7'd0, page_err}, 8'h00);
    idle(SETTLE);

    // R9: strobes during programming
    wr(9'h060, 8'h66, 4); idle(60);
    wr(9'h020, 8'h00, 4);
    rd_chk("R9 poll target kept", 9'h060, 8'hE6);
    idle(SETTLE);
    rd_chk("R9 array untouched", 9'h020, 8'hA5);
    rd_chk("R9 own byte done", 9'h060, 8'h66);

    // R6: gaps shorter than the window keep the page open
    wr(9'h070, 8'h0F, 4); idle(SETTLE);
    wr(9'h070, 8'h01, 4); idle(30);
    rd_chk("R6 still loading 1", 9'h070, 8'h0F);
    wr(9'h071, 8'h02, 4); idle(30);
    rd_chk("R6 still loading 2", 9'h070, 8'h0F);
    idle(20);
    rd_chk("R6 window expired R8 poll", 9'h071, 8'h82);
    idle(SETTLE);
    rd_chk("R6 byte a", 9'h070, 8'h01);
    rd_chk("R6 byte b", 9'h071, 8'h02);

    // R7: partial update keeps other bytes, full page commits together
    wr(9'h022, 8'h5C, 4); idle(SETTLE);
    rd_chk("R7 partial new", 9'h022, 8'h5C);
    rd_chk("R7 partial neighbour", 9'h020, 8'hA5);
    for (int i = 0; i < 16; i++) begin
      wr({5'h08, 4'(i)}, 8'(i * 29 + 3), 4);
    end
    idle(60);
    rd_chk("R8 full page poll", 9'h08F, 8'h36);
    idle(SETTLE);
    for (int i = 0; i < 16; i++) begin
      rd_chk("R7 full page", {5'h08, 4'(i)}, 8'(i * 29 + 3));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule